// File: doc/BRIEF.md
# Command Frame Receiver with CRC-16 Check

This block sits behind a serial byte receiver and turns its raw byte stream into checked command frames. Each frame opens with a 16-bit little-endian length, then carries a type byte, a sequence byte and a payload. It closes with a 16-bit CRC. The length counts the type byte, the sequence byte and the payload. The block parses the header, checks the length against a configured ceiling, and computes a CRC over the type byte, the sequence byte and the payload. It keeps the frame's bytes in an internal buffer and releases them downstream only after the received CRC matches.

Downstream logic sees each good frame as a valid/ready stream of payload bytes. Every beat carries the frame's type and sequence bytes, plus first-beat and last-beat markers. The sequence byte is passed through untouched, so that a request can later be paired with its reply. Three one-cycle status pulses report a good frame, a CRC mismatch and a bad length. A fourth pulse reports a byte that was refused because the buffer was full.

The byte input has no back-pressure. While the output stream is stalled, the buffer keeps filling. A new frame can be received while earlier frames are still draining, as long as buffer space remains. A long silence in the middle of a frame drops the partial frame, and the parser starts again with a fresh length field.

Top module: `crcframe_rx`

## Requirements
- R1: Bytes are taken in this order: length low, length high, type, sequence, then (length minus 2) payload bytes, CRC low, CRC high.
- R2: The CRC is CRC-16 with polynomial 0x1021, start value 0xFFFF, no bit reflection and no final XOR. It runs over the type byte, the sequence byte and the payload, and not over the length bytes. When the received value (low byte first) matches, `frame_ok` pulses for one cycle.
- R3: On a CRC mismatch, `crc_err` pulses for one cycle and no beat of that frame reaches the output.
- R4: A length below 2 or above `MAX_LEN` pulses `len_err` once, after the length high byte. The next byte is then taken as a new length low byte. A length of exactly `MAX_LEN` is accepted.
- R5: Every beat carries the frame's type on `out_type` and its unchanged sequence byte on `out_seq`. `out_sof` marks the first payload beat and `out_eof` marks the last. A frame with no payload gives a single beat with `out_nodata`=1, `out_sof`=1, `out_eof`=1 and `out_data`=0.
- R6: Back-pressure: a beat with `out_valid`=1 and `out_ready`=0 holds all output fields stable until it is taken. Frames leave in arrival order, and their content does not depend on the `out_ready` pattern.
- R7: No beat of a frame is presented before that frame's CRC high byte has been received and checked.
- R8: If `GAP_BYTES*CLKS_PER_BYTE` or more consecutive cycles pass with no byte while a frame is in progress, the partial frame is dropped with no status pulse. The next byte is taken as a length low byte. A gap one cycle shorter than this limit is tolerated.
- R9: The buffer holds `MAX_LEN` entries, and each frame uses 2 plus its payload length. A new frame is accepted while earlier frames drain. A type, sequence or payload byte that finds the buffer full pulses `overflow`, and so does every later byte of that frame's body. Such a frame is then dropped at its end without `frame_ok` or `crc_err`.
- R10: During and right after reset, `out_valid` and all status pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A received byte is present this cycle |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 8 | Payload byte (0 on a no-payload beat) |
| out_sof | output | 1 | First beat of a frame |
| out_eof | output | 1 | Last beat of a frame |
| out_nodata | output | 1 | Beat of a frame with no payload |
| out_type | output | 8 | Type byte of the current frame |
| out_seq | output | 8 | Sequence byte of the current frame |
| frame_ok | output | 1 | Pulse: CRC matched |
| crc_err | output | 1 | Pulse: CRC mismatch |
| len_err | output | 1 | Pulse: length out of range |
| overflow | output | 1 | Pulse: byte refused, buffer full |

## Verification
Two functions can act in the same cycle: the output stage reading buffered bytes of an earlier frame, and the parser committing or rolling back a later frame. The bench provokes this by stalling the output while two frames arrive, then releasing it with a broken ready pattern while a third frame arrives slowly. The test passes only if all three frames come out whole and in order. A second case lets the stalled output stage free only three entries, then sends a frame that overruns part way. The test then counts the overflow pulses exactly and checks that the bytes already written are rolled back, so that only the first frame appears.

// File: rtl/crcframe_pkg.sv
package crcframe_pkg;

  typedef enum logic [2:0] {
    PS_LEN_LO, PS_LEN_HI, PS_TYPE, PS_SEQ, PS_BODY, PS_CRC_LO, PS_CRC_HI
  } parse_state_e;

  typedef enum logic [1:0] {
    ES_TYPE, ES_SEQ, ES_BODY
  } emit_state_e;

  // One buffer slot: a byte and a flag marking the final byte of its frame.
  typedef struct packed {
    logic       last;
    logic [7:0] data;
  } buf_entry_t;

  // One byte of CRC-16, polynomial 0x1021, MSB first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                             input logic [7:0]  b);
    logic [15:0] c;
    c = crc_in ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      c = c[15] ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/crcframe_parse.sv
module crcframe_parse
  import crcframe_pkg::*;
#(
  parameter int MAX_LEN    = 258,
  parameter int GAP_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       buf_full,
  output logic       wr_en,
  output buf_entry_t wr_entry,
  output logic       commit,
  output logic       rollback,
  output logic       ok_pulse,
  output logic       crc_err_pulse,
  output logic       len_err_pulse,
  output logic       ovf_pulse
);
  localparam int CW = $clog2(MAX_LEN + 1);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  parse_state_e   state_q;
  logic [7:0]     len_lo_q;
  logic [CW-1:0]  remain_q;
  logic [15:0]    crc_q;
  logic [7:0]     crc_lo_q;
  logic           drop_q;
  logic [GW-1:0]  gap_q;

  logic [15:0] len_w;
  logic        body_byte, drop_eff, ovf_now, crc_match, timeout;

  always_comb begin
    len_w     = {in_data, len_lo_q};
    body_byte = in_valid && (state_q == PS_TYPE || state_q == PS_SEQ ||
                             state_q == PS_BODY);
    drop_eff  = (state_q == PS_TYPE) ? 1'b0 : drop_q;
    ovf_now   = body_byte && (drop_eff || buf_full);
    wr_en     = body_byte && !drop_eff && !buf_full;
    wr_entry.data = in_data;
    wr_entry.last = (state_q == PS_SEQ  && remain_q == '0) ||
                    (state_q == PS_BODY && remain_q == CW'(1));
    crc_match = ({in_data, crc_lo_q} == crc_q);
    timeout   = !in_valid && state_q != PS_LEN_LO &&
                gap_q == GW'(GAP_CYCLES - 1);
    commit    = in_valid && state_q == PS_CRC_HI && !drop_q && crc_match;
    rollback  = (in_valid && state_q == PS_CRC_HI && !commit) || timeout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= PS_LEN_LO;
      len_lo_q      <= '0;
      remain_q      <= '0;
      crc_q         <= 16'hFFFF;
      crc_lo_q      <= '0;
      drop_q        <= 1'b0;
      gap_q         <= '0;
      ok_pulse      <= 1'b0;
      crc_err_pulse <= 1'b0;
      len_err_pulse <= 1'b0;
      ovf_pulse     <= 1'b0;
    end else begin
      ok_pulse      <= 1'b0;
      crc_err_pulse <= 1'b0;
      len_err_pulse <= 1'b0;
      ovf_pulse     <= ovf_now;
      if (in_valid) begin
        gap_q <= '0;
        unique case (state_q)
          PS_LEN_LO: begin
            len_lo_q <= in_data;
            state_q  <= PS_LEN_HI;
          end
          PS_LEN_HI: begin
            if (len_w < 16'd2 || len_w > 16'(MAX_LEN)) begin
              len_err_pulse <= 1'b1;
              state_q       <= PS_LEN_LO;
            end else begin
              remain_q <= CW'(len_w - 16'd2);
              state_q  <= PS_TYPE;
            end
          end
          PS_TYPE: begin
            crc_q   <= crc16_byte(16'hFFFF, in_data);
            drop_q  <= ovf_now;
            state_q <= PS_SEQ;
          end
          PS_SEQ: begin
            crc_q   <= crc16_byte(crc_q, in_data);
            drop_q  <= drop_q | ovf_now;
            state_q <= (remain_q == '0) ? PS_CRC_LO : PS_BODY;
          end
          PS_BODY: begin
            crc_q    <= crc16_byte(crc_q, in_data);
            drop_q   <= drop_q | ovf_now;
            remain_q <= remain_q - CW'(1);
            if (remain_q == CW'(1)) state_q <= PS_CRC_LO;
          end
          PS_CRC_LO: begin
            crc_lo_q <= in_data;
            state_q  <= PS_CRC_HI;
          end
          PS_CRC_HI: begin
            state_q <= PS_LEN_LO;
            if (!drop_q) begin
              if (crc_match) ok_pulse      <= 1'b1;
              else           crc_err_pulse <= 1'b1;
            end
          end
          default: state_q <= PS_LEN_LO;
        endcase
      end else if (state_q != PS_LEN_LO) begin
        if (timeout) begin
          state_q <= PS_LEN_LO;
          gap_q   <= '0;
        end else begin
          gap_q <= gap_q + GW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/crcframe_buf.sv
module crcframe_buf
  import crcframe_pkg::*;
#(
  parameter int DEPTH = 258
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  buf_entry_t wr_entry,
  input  logic       commit,
  input  logic       rollback,
  output logic       full,
  input  logic       rd_en,
  output buf_entry_t rd_entry,
  output logic       rd_avail
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] ONE = CNTW'(1);

  buf_entry_t      mem [DEPTH];
  logic [AW-1:0]   wr_ptr_q, base_ptr_q, rd_ptr_q;
  logic [CNTW-1:0] fill_q, ccnt_q, spec_q;
  logic [CNTW-1:0] fill_d, ccnt_d;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    full     = (fill_q == CNTW'(DEPTH));
    rd_avail = (ccnt_q != '0);
    rd_entry = mem[rd_ptr_q];
    fill_d = fill_q;
    if (wr_en)    fill_d = fill_d + ONE;
    if (rd_en)    fill_d = fill_d - ONE;
    if (rollback) fill_d = fill_d - spec_q;
    ccnt_d = ccnt_q;
    if (commit)   ccnt_d = ccnt_d + spec_q;
    if (rd_en)    ccnt_d = ccnt_d - ONE;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q   <= '0;
      base_ptr_q <= '0;
      rd_ptr_q   <= '0;
      fill_q     <= '0;
      ccnt_q     <= '0;
      spec_q     <= '0;
    end else begin
      if (rollback)   wr_ptr_q <= base_ptr_q;
      else if (wr_en) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (commit)     base_ptr_q <= wr_ptr_q;
      if (rd_en)      rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (commit || rollback) spec_q <= '0;
      else if (wr_en)         spec_q <= spec_q + ONE;
      fill_q <= fill_d;
      ccnt_q <= ccnt_d;
    end
  end

endmodule

// File: rtl/crcframe_emit.sv
module crcframe_emit
  import crcframe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_avail,
  input  buf_entry_t rd_entry,
  output logic       rd_en,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       out_nodata,
  output logic [7:0] out_type,
  output logic [7:0] out_seq
);
  emit_state_e es_q;
  logic [7:0]  type_q, seq_q;
  logic        first_q;
  logic        load_ok;

  always_comb begin
    load_ok = !out_valid || out_ready;
    unique case (es_q)
      ES_TYPE: rd_en = rd_avail;
      ES_SEQ:  rd_en = rd_avail && (!rd_entry.last || load_ok);
      ES_BODY: rd_en = rd_avail && load_ok;
      default: rd_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      es_q       <= ES_TYPE;
      type_q     <= '0;
      seq_q      <= '0;
      first_q    <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
      out_nodata <= 1'b0;
      out_type   <= '0;
      out_seq    <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      unique case (es_q)
        ES_TYPE: if (rd_en) begin
          type_q <= rd_entry.data;
          es_q   <= ES_SEQ;
        end
        ES_SEQ: if (rd_en) begin
          seq_q   <= rd_entry.data;
          first_q <= 1'b1;
          if (rd_entry.last) begin
            out_valid  <= 1'b1;
            out_data   <= '0;
            out_sof    <= 1'b1;
            out_eof    <= 1'b1;
            out_nodata <= 1'b1;
            out_type   <= type_q;
            out_seq    <= rd_entry.data;
            es_q       <= ES_TYPE;
          end else begin
            es_q <= ES_BODY;
          end
        end
        ES_BODY: if (rd_en) begin
          out_valid  <= 1'b1;
          out_data   <= rd_entry.data;
          out_sof    <= first_q;
          out_eof    <= rd_entry.last;
          out_nodata <= 1'b0;
          out_type   <= type_q;
          out_seq    <= seq_q;
          first_q    <= 1'b0;
          if (rd_entry.last) es_q <= ES_TYPE;
        end
        default: es_q <= ES_TYPE;
      endcase
    end
  end

endmodule

// File: rtl/crcframe_rx.sv
module crcframe_rx
  import crcframe_pkg::*;
#(
  parameter int MAX_LEN       = 258,
  parameter int CLKS_PER_BYTE = 500,
  parameter int GAP_BYTES     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       out_nodata,
  output logic [7:0] out_type,
  output logic [7:0] out_seq,
  output logic       frame_ok,
  output logic       crc_err,
  output logic       len_err,
  output logic       overflow
);
  localparam int GAP_CYCLES = CLKS_PER_BYTE * GAP_BYTES;
  localparam int DEPTH      = MAX_LEN;

  logic       wr_en, commit, rollback, buf_full, rd_en, rd_avail;
  buf_entry_t wr_entry, rd_entry;

  crcframe_parse #(.MAX_LEN(MAX_LEN), .GAP_CYCLES(GAP_CYCLES)) u_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .buf_full(buf_full), .wr_en(wr_en), .wr_entry(wr_entry),
    .commit(commit), .rollback(rollback), .ok_pulse(frame_ok),
    .crc_err_pulse(crc_err), .len_err_pulse(len_err), .ovf_pulse(overflow)
  );

  crcframe_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_entry(wr_entry),
    .commit(commit), .rollback(rollback), .full(buf_full),
    .rd_en(rd_en), .rd_entry(rd_entry), .rd_avail(rd_avail)
  );

  crcframe_emit u_emit (
    .clk(clk), .rst_n(rst_n), .rd_avail(rd_avail), .rd_entry(rd_entry),
    .rd_en(rd_en), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .out_nodata(out_nodata), .out_type(out_type), .out_seq(out_seq)
  );

endmodule

// File: rtl/crcframe_rx_chk.sv
module crcframe_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof,
  input logic       out_nodata,
  input logic [7:0] out_type,
  input logic [7:0] out_seq,
  input logic       frame_ok,
  input logic       crc_err,
  input logic       len_err,
  input logic       overflow
);
  logic        in_frame_q;
  logic [15:0] credit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      credit_q   <= '0;
    end else begin
      if (out_valid && out_ready) in_frame_q <= !out_eof;
      credit_q <= credit_q + {15'd0, frame_ok}
                           - {15'd0, (out_valid && out_ready && out_sof)};
    end
  end

  // R6: a stalled beat keeps every field
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
      $stable(out_sof) && $stable(out_eof) && $stable(out_nodata) &&
      $stable(out_type) && $stable(out_seq));

  // R3: status pulses never coincide
  p_excl_pulses_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_ok, crc_err, len_err, overflow}));

  // R5: an empty-payload beat is both first and last
  p_nodata_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_nodata |-> out_sof && out_eof);

  // R5: start marker exactly on the beat after an end marker
  p_sof_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !in_frame_q |-> out_sof);

  p_sof_inner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && in_frame_q |-> !out_sof);

  // R7: a frame starts only after its CRC passed
  p_release_after_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> credit_q != 16'd0);

endmodule

bind crcframe_rx crcframe_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
  .out_nodata(out_nodata), .out_type(out_type), .out_seq(out_seq),
  .frame_ok(frame_ok), .crc_err(crc_err), .len_err(len_err),
  .overflow(overflow)
);

// File: tb/crcframe_rx_tb.sv
`timescale 1ns/1ps
module crcframe_rx_tb;
  localparam int MAX_LEN = 10;
  localparam int CPB     = 4;
  localparam int GAPB    = 3;
  localparam int GAP     = CPB * GAPB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_ready = 1'b0;
  logic out_valid, out_sof, out_eof, out_nodata;
  logic [7:0] out_data, out_type, out_seq;
  logic frame_ok, crc_err, len_err, overflow;

  always #10 clk = ~clk;

  crcframe_rx #(.MAX_LEN(MAX_LEN), .CLKS_PER_BYTE(CPB), .GAP_BYTES(GAPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_nodata(out_nodata),
    .out_type(out_type), .out_seq(out_seq), .frame_ok(frame_ok),
    .crc_err(crc_err), .len_err(len_err), .overflow(overflow)
  );

  int checks = 0, errors = 0;
  int n_ok = 0, n_crc = 0, n_len = 0, n_ovf = 0;
  int b_ok, b_crc, b_len, b_ovf;
  int ready_mode = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [26:0] exp_q[$];
  logic [7:0] fb_g[0:31];
  int tot_g;

  task automatic check(input bit ok, input string msg, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  // Monitor: drives ready, counts pulses, checks accepted beats (R1 R5 R6).
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      case (ready_mode)
        0: out_ready = 1'b0;
        1: out_ready = 1'b1;
        default: out_ready = (cyc % 3) != 0;
      endcase
      if (frame_ok) n_ok++;
      if (crc_err)  n_crc++;
      if (len_err)  n_len++;
      if (overflow) n_ovf++;
      if (rst_n && out_valid && out_ready) begin
        logic [26:0] act;
        act = {out_nodata, out_sof, out_eof, out_type, out_seq, out_data};
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 R5 unexpected output beat", act, 0);
        end else begin
          logic [26:0] e;
          e = exp_q.pop_front();
          check(act == e, "R1 R5 R6 beat content", act, e);
        end
      end
    end
  end

  function automatic logic [15:0] tb_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic fbit;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      fbit = r[15] ^ b[k];
      r = {r[14:0], 1'b0};
      if (fbit) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Builds a frame into fb_g; optionally flips a bit and queues expected beats.
  task automatic build(input logic [7:0] typ, input logic [7:0] sq, input int n,
                       input int flip, input bit expect_out);
    logic [15:0] c;
    tot_g = n + 6;
    fb_g[0] = 8'(n + 2);
    fb_g[1] = 8'((n + 2) >> 8);
    fb_g[2] = typ;
    fb_g[3] = sq;
    for (int i = 0; i < n; i++) fb_g[4+i] = 8'(typ * 7 + i * 13 + sq);
    c = 16'hFFFF;
    for (int i = 2; i < 4 + n; i++) c = tb_crc(c, fb_g[i]);
    fb_g[4+n] = c[7:0];
    fb_g[5+n] = c[15:8];
    if (flip >= 0) fb_g[flip] = fb_g[flip] ^ 8'h01;
    if (expect_out) begin
      if (n == 0) exp_q.push_back({1'b1, 1'b1, 1'b1, typ, sq, 8'h00});
      for (int i = 0; i < n; i++)
        exp_q.push_back({1'b0, i == 0, i == n - 1, typ, sq, fb_g[4+i]});
    end
  endtask

  task automatic send_bytes(input int a, input int b, input int gap);
    for (int i = a; i <= b; i++) begin
      put(fb_g[i]);
      if (i != b) idle(gap);
    end
  endtask

  task automatic send_frame(input logic [7:0] typ, input logic [7:0] sq, input int n,
                            input int gap, input int flip, input bit expect_out);
    build(typ, sq, n, flip, expect_out);
    send_bytes(0, tot_g - 1, gap);
    idle(1);
  endtask

  task automatic drain(input string tag);
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    idle(6);
    check(exp_q.size() == 0, {tag, " all expected beats delivered"}, exp_q.size(), 0);
    check(out_valid == 1'b0, {tag, " output idle after drain"}, out_valid, 0);
  endtask

  task automatic snap();
    b_ok = n_ok; b_crc = n_crc; b_len = n_len; b_ovf = n_ovf;
  endtask

  task automatic counts(input int eok, input int ecrc, input int elen, input int eovf,
                        input string tag);
    check(n_ok - b_ok == eok,   {tag, " frame_ok count"}, n_ok - b_ok, eok);
    check(n_crc - b_crc == ecrc, {tag, " crc_err count"}, n_crc - b_crc, ecrc);
    check(n_len - b_len == elen, {tag, " len_err count"}, n_len - b_len, elen);
    check(n_ovf - b_ovf == eovf, {tag, " overflow count"}, n_ovf - b_ovf, eovf);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R6: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    idle(5);
    check(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
    check({frame_ok, crc_err, len_err, overflow} == 4'b0, "R10 pulses in reset",
          {frame_ok, crc_err, len_err, overflow}, 0);
    rst_n = 1'b1;
    idle(3);
    check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    snap();
    counts(0, 0, 0, 0, "R10");

    // R1 R2 R5: sweep every payload length, ready held high
    ready_mode = 1;
    snap();
    for (int n = 0; n <= MAX_LEN - 2; n++) send_frame(8'(8'h10 + n), 8'(n * 37 + 1), n, 0, -1, 1'b1);
    drain("R1 R2 sweep");
    counts(MAX_LEN - 1, 0, 0, 0, "R2 sweep");

    // R6: same sweep under a broken ready pattern, spaced bytes
    ready_mode = 2;
    snap();
    for (int n = 0; n <= MAX_LEN - 2; n++) send_frame(8'(8'hA0 + n), 8'(255 - n), n, 1, -1, 1'b1);
    drain("R6 throttled");
    counts(MAX_LEN - 1, 0, 0, 0, "R6 throttled");

    // R7: nothing presented before the CRC high byte
    ready_mode = 1;
    snap();
    build(8'h55, 8'h66, 3, -1, 1'b1);
    send_bytes(0, tot_g - 2, 0);
    idle(5);
    check(out_valid == 1'b0, "R7 no beat before CRC high byte", out_valid, 0);
    counts(0, 0, 0, 0, "R7 before CRC");
    send_bytes(tot_g - 1, tot_g - 1, 0);
    idle(1);
    drain("R7");
    counts(1, 0, 0, 0, "R7 after CRC");

    // R3: flip a bit in each CRC-covered or CRC byte
    snap();
    for (int f = 2; f <= 8; f++) send_frame(8'h31, 8'(f), 3, 0, f, 1'b0);
    send_frame(8'h32, 8'h99, 2, 0, -1, 1'b1);
    drain("R3");
    counts(1, 7, 0, 0, "R3 corrupted frames");

    // R4: out-of-range lengths, then a maximum-length frame
    snap();
    put(8'd0);  put(8'd0);  idle(1);
    put(8'd1);  put(8'd0);  idle(1);
    put(8'(MAX_LEN + 1)); put(8'd0); idle(1);
    put(8'hFF); put(8'hFF); idle(1);
    idle(2);
    counts(0, 0, 4, 0, "R4 bad lengths");
    snap();
    send_frame(8'h44, 8'h07, MAX_LEN - 2, 0, -1, 1'b1);
    drain("R4 max length");
    counts(1, 0, 0, 0, "R4 max length accepted");

    // R8: gap just under the limit is tolerated, at the limit drops the frame
    snap();
    send_frame(8'h61, 8'h01, 4, GAP - 1, -1, 1'b1);
    drain("R8 tolerated gap");
    counts(1, 0, 0, 0, "R8 tolerated gap");
    snap();
    build(8'h62, 8'h02, 4, -1, 1'b0);
    send_bytes(0, 2, 0);
    idle(GAP);
    build(8'h63, 8'h03, 4, -1, 1'b0);
    send_bytes(0, 5, 0);
    idle(GAP);
    send_frame(8'h64, 8'h04, 2, 0, -1, 1'b1);
    drain("R8 aborted frames");
    counts(1, 0, 0, 0, "R8 aborted frames");

    // R9: frames accepted while earlier ones drain
    ready_mode = 0;
    snap();
    send_frame(8'h71, 8'h11, 3, 0, -1, 1'b1);
    send_frame(8'h72, 8'h12, 3, 0, -1, 1'b1);
    idle(4);
    ready_mode = 2;
    send_frame(8'h73, 8'h13, 2, 3, -1, 1'b1);
    drain("R9 overlap");
    counts(3, 0, 0, 0, "R9 overlap");

    // R9: overflow part way through a frame (3 entries freed by the stalled output)
    ready_mode = 0;
    snap();
    send_frame(8'h81, 8'h21, MAX_LEN - 2, 0, -1, 1'b1);
    idle(6);
    send_frame(8'h82, 8'h22, 4, 0, -1, 1'b0);
    idle(2);
    counts(1, 0, 0, 3, "R9 overflow");
    ready_mode = 1;
    drain("R9 overflow drain");
    snap();
    send_frame(8'h83, 8'h23, 5, 0, -1, 1'b1);
    drain("R9 after overflow");
    counts(1, 0, 0, 0, "R9 after overflow");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule